// File: doc/BRIEF.md
# Sharing-Classification Coherence State Controller

This block keeps the coherence bookkeeping for the lines of one shared L2 bank in a small multi-core system whose cores have private L1 caches. No list of sharers is kept. Each line carries four bits: a present flag and three classification bits. The classification bits are a sticky "touched by more than one core" bit, a sticky "has been written" bit, and a flag that says the single ownership token is parked at L2 rather than in some L1. These bits sort every line into one of two groups. A line that is private, or only read, may be cached in L1. A line that is both shared and written is pulled back to L2 and served from there only.

L1s send reads, writes, L1 eviction notices and L2 eviction notices over a valid/ready request port. Each request carries the core number, the line index and a flag telling whether the requester holds the token. The controller answers every read and write one cycle after acceptance. The answer says whether the line may be cached, whether the token was handed to the requester, and whether the write is acknowledged. When a line is first classified as shared and written, the controller raises a broadcast invalidation request and holds it until the bus grants it. While that request is pending, further requests to the same line are stalled, so the protocol needs no transient states.

Top module: `coh_class_ctrl`

## Requirements
- R1: After reset every line is absent, `req_ready` is 1, and `rsp_valid` and `inv_req` are 0.
- R2: A read or write to an absent line makes the line present. The response has `rsp_cacheable`=1 and `rsp_token`=1, so the token moves to the requester's L1. A granted token always comes with `rsp_cacheable`=1.
- R3: `rsp_ack`=1 is given for a write that sets the written bit for the first time while the line stays private (writer holds the token, or takes it from L2). It is also given for every write to a shared-and-written line. Reads never get `rsp_ack`.
- R4: An L1 eviction (`req_op`=2'b10) with `req_tok`=1 on a private line returns the token to L2. The next read from any core is then granted the token with `rsp_cacheable`=1 and no invalidation.
- R5: A read with `req_tok`=0, while L2 does not hold the token, sets the shared bit. The line becomes shared-read: the response has `rsp_cacheable`=1, `rsp_token`=0 and there is no invalidation. The shared bit stays set, so later reads are never granted the token, even after the token returns to L2.
- R6: A line enters shared-written in three cases: a write to a shared-read line; any access with `req_tok`=0 to a private written line; a write with `req_tok`=0 to a private read line. On that entry the response has `rsp_cacheable`=0, `inv_req` rises in the same cycle as `rsp_valid`, and `inv_line` carries the line index.
- R7: `inv_req` and `inv_line` hold until a cycle with `inv_gnt`=1, after which `inv_req` is 0. While `inv_req` is 1, a request to `inv_line` sees `req_ready`=0, and a request to another line that needs no invalidation is accepted.
- R8: A shared-written line stays shared-written. Every read or write to it gets `rsp_cacheable`=0 and `rsp_token`=0 and raises no new invalidation, whatever the token flag. An L1 eviction leaves it unchanged.
- R9: An L2 eviction (`req_op`=2'b11) clears all bits of the line. The next read is handled as a first read (R2).
- R10: `rsp_valid` is 1 exactly in the cycle after a read (`req_op`=2'b00) or write (2'b01) is accepted, with `rsp_core` equal to that request's core. Evictions produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_op | input | 2 | 00 read, 01 write, 10 L1 eviction, 11 L2 eviction |
| req_core | input | CORE_W (4) | Requesting core |
| req_line | input | LINE_W (6) | Line index in the bank |
| req_tok | input | 1 | Requester holds the ownership token |
| rsp_valid | output | 1 | Response to a read or write |
| rsp_core | output | CORE_W (4) | Core the response is for |
| rsp_cacheable | output | 1 | Line may be kept in L1 |
| rsp_token | output | 1 | Token handed to the requester |
| rsp_ack | output | 1 | Write acknowledged |
| inv_req | output | 1 | Broadcast invalidation requested |
| inv_line | output | LINE_W (6) | Line to invalidate |
| inv_gnt | input | 1 | Broadcast bus grant |

## Verification
The assertions assume that the bus never raises `inv_gnt` unless `inv_req` is high. They also assume that the token flag on a request is honest, meaning only the L1 that was actually handed the token sets it. The directed tasks raise the grant only while an invalidation is pending. The token flag is set only for the core that the bench saw receive `rsp_token`, or for the holder whose token L2 has already reclaimed. `req_valid` is held low during reset.

// File: rtl/coh_pkg.sv
package coh_pkg;

   typedef enum logic [1:0] {
      OP_RD      = 2'b00,
      OP_WR      = 2'b01,
      OP_L1EVICT = 2'b10,
      OP_L2EVICT = 2'b11
   } coh_op_e;

   typedef struct packed {
      logic present;   // line allocated in this bank
      logic shr;       // touched by more than one core (sticky)
      logic wr;        // written at least once (sticky)
      logic tok_home;  // ownership token parked at L2
   } line_st_t;

   localparam int unsigned LINE_ST_W = $bits(line_st_t);

endpackage

// File: rtl/coh_line_store.sv
module coh_line_store
   import coh_pkg::*;
#(
   parameter int unsigned NUM_LINES = 64,
   localparam int unsigned LINE_W = $clog2(NUM_LINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LINE_W-1:0] rd_idx,
   output line_st_t          rd_st,
   input  logic              we,
   input  logic [LINE_W-1:0] wr_idx,
   input  line_st_t          wr_st
);

   line_st_t mem [NUM_LINES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_LINES; i++) mem[i] <= '0;
      end else if (we) begin
         mem[wr_idx] <= wr_st;
      end
   end

   assign rd_st = mem[rd_idx];

endmodule

// File: rtl/coh_decide.sv
module coh_decide
   import coh_pkg::*;
(
   input  line_st_t st_cur,
   input  coh_op_e  op,
   input  logic     tok,
   output line_st_t st_nxt,
   output logic     rsp_en,
   output logic     cacheable,
   output logic     grant,
   output logic     ack,
   output logic     start_inv
);

   logic is_wr;
   assign is_wr = (op == OP_WR);

   always_comb begin
      st_nxt    = st_cur;
      rsp_en    = 1'b0;
      cacheable = 1'b0;
      grant     = 1'b0;
      ack       = 1'b0;
      start_inv = 1'b0;
      case (op)
         OP_RD, OP_WR: begin
            rsp_en = 1'b1;
            if (!st_cur.present) begin
               // first touch: token goes straight to the requester
               st_nxt.present  = 1'b1;
               st_nxt.shr      = 1'b0;
               st_nxt.wr       = is_wr;
               st_nxt.tok_home = 1'b0;
               cacheable       = 1'b1;
               grant           = 1'b1;
               ack             = is_wr;
            end else if (st_cur.shr && st_cur.wr) begin
               // relegated to L2 for good
               ack = is_wr;
            end else if (st_cur.shr) begin
               if (is_wr) begin
                  st_nxt.wr       = 1'b1;
                  st_nxt.tok_home = 1'b1;
                  start_inv       = 1'b1;
                  ack             = 1'b1;
               end else begin
                  cacheable = 1'b1;
               end
            end else if (st_cur.tok_home) begin
               // private line, token idle at L2: hand it out
               st_nxt.tok_home = 1'b0;
               st_nxt.wr       = st_cur.wr | is_wr;
               cacheable       = 1'b1;
               grant           = 1'b1;
               ack             = is_wr & ~st_cur.wr;
            end else if (tok) begin
               st_nxt.wr = st_cur.wr | is_wr;
               cacheable = 1'b1;
               ack       = is_wr & ~st_cur.wr;
            end else begin
               // a second core shows up
               st_nxt.shr = 1'b1;
               if (st_cur.wr || is_wr) begin
                  st_nxt.wr       = 1'b1;
                  st_nxt.tok_home = 1'b1;
                  start_inv       = 1'b1;
                  ack             = is_wr;
               end else begin
                  cacheable = 1'b1;
               end
            end
         end
         OP_L1EVICT: begin
            if (st_cur.present && tok && !(st_cur.shr && st_cur.wr))
               st_nxt.tok_home = 1'b1;
         end
         default: begin
            st_nxt = '0;
         end
      endcase
   end

endmodule

// File: rtl/coh_inval_ctrl.sv
module coh_inval_ctrl #(
   parameter int unsigned LINE_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [LINE_W-1:0] start_line,
   input  logic              gnt,
   output logic              pend,
   output logic [LINE_W-1:0] line
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend <= 1'b0;
         line <= '0;
      end else if (start) begin
         pend <= 1'b1;
         line <= start_line;
      end else if (gnt) begin
         pend <= 1'b0;
      end
   end

   AST_INV_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !pend); // R7

endmodule

// File: rtl/coh_class_ctrl.sv
module coh_class_ctrl
   import coh_pkg::*;
#(
   parameter int unsigned NUM_CORES        = 16,
   parameter int unsigned NUM_LINES        = 64,
   parameter bit          STALL_ALL_ON_INV = 1'b0,
   localparam int unsigned CORE_W = $clog2(NUM_CORES),
   localparam int unsigned LINE_W = $clog2(NUM_LINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [1:0]        req_op,
   input  logic [CORE_W-1:0] req_core,
   input  logic [LINE_W-1:0] req_line,
   input  logic              req_tok,
   output logic              rsp_valid,
   output logic [CORE_W-1:0] rsp_core,
   output logic              rsp_cacheable,
   output logic              rsp_token,
   output logic              rsp_ack,
   output logic              inv_req,
   output logic [LINE_W-1:0] inv_line,
   input  logic              inv_gnt
);

   if (NUM_CORES < 2) begin : g_bad_cores
      $error("coh_class_ctrl: NUM_CORES must be at least 2");
   end
   if (NUM_LINES < 2) begin : g_bad_lines
      $error("coh_class_ctrl: NUM_LINES must be at least 2");
   end

   coh_op_e  op;
   line_st_t st_cur, st_nxt;
   logic     d_rsp, d_cache, d_grant, d_ack, d_inv;
   logic     accept, acc_rw;

   assign op = coh_op_e'(req_op);

   coh_line_store #(.NUM_LINES(NUM_LINES)) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_idx (req_line),
      .rd_st  (st_cur),
      .we     (accept),
      .wr_idx (req_line),
      .wr_st  (st_nxt)
   );

   coh_decide u_decide (
      .st_cur    (st_cur),
      .op        (op),
      .tok       (req_tok),
      .st_nxt    (st_nxt),
      .rsp_en    (d_rsp),
      .cacheable (d_cache),
      .grant     (d_grant),
      .ack       (d_ack),
      .start_inv (d_inv)
   );

   coh_inval_ctrl #(.LINE_W(LINE_W)) u_inval (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (accept & d_inv),
      .start_line (req_line),
      .gnt        (inv_gnt),
      .pend       (inv_req),
      .line       (inv_line)
   );

   if (STALL_ALL_ON_INV) begin : g_stall_all
      assign req_ready = !inv_req;
   end else begin : g_stall_line
      assign req_ready = !(inv_req && ((req_line == inv_line) || d_inv));
   end

   assign accept = req_valid & req_ready;
   assign acc_rw = accept & d_rsp;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid     <= 1'b0;
         rsp_core      <= '0;
         rsp_cacheable <= 1'b0;
         rsp_token     <= 1'b0;
         rsp_ack       <= 1'b0;
      end else begin
         rsp_valid     <= acc_rw;
         rsp_core      <= acc_rw ? req_core : rsp_core;
         rsp_cacheable <= acc_rw & d_cache;
         rsp_token     <= acc_rw & d_grant;
         rsp_ack       <= acc_rw & d_ack;
      end
   end

   AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      acc_rw |=> rsp_valid); // R10
   AST_RSP_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(acc_rw)); // R10
   AST_TOKEN_CACHEABLE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_token |-> rsp_cacheable); // R2
   AST_READ_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      acc_rw && op == OP_RD |=> !rsp_ack); // R3
   AST_INV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      inv_req && !inv_gnt |=> inv_req && $stable(inv_line)); // R7
   AST_INV_LINE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      inv_req && req_valid && req_line == inv_line |-> !req_ready); // R7
   AST_SW_STAYS_L2: assert property (@(posedge clk) disable iff (!rst_n)
      acc_rw && st_cur.shr && st_cur.wr |=> rsp_valid && !rsp_cacheable && !rsp_token && !$rose(inv_req)); // R8

endmodule

// File: tb/coh_class_ctrl_test.sv
`timescale 1ns/1ps
module coh_class_ctrl_test;

   localparam int CW = 4;
   localparam int LW = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [1:0]    req_op = 2'b00;
   logic [CW-1:0] req_core = '0;
   logic [LW-1:0] req_line = '0;
   logic          req_tok = 1'b0;
   logic          rsp_valid;
   logic [CW-1:0] rsp_core;
   logic          rsp_cacheable, rsp_token, rsp_ack;
   logic          inv_req;
   logic [LW-1:0] inv_line;
   logic          inv_gnt = 1'b0;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   // response captured by the last issue
   logic r_v, r_c, r_t, r_a, r_i;
   logic [CW-1:0] r_core;
   logic [LW-1:0] r_il;

   always #2.5 clk = ~clk;

   coh_class_ctrl uut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
      .req_core(req_core), .req_line(req_line), .req_tok(req_tok),
      .rsp_valid(rsp_valid), .rsp_core(rsp_core), .rsp_cacheable(rsp_cacheable),
      .rsp_token(rsp_token), .rsp_ack(rsp_ack),
      .inv_req(inv_req), .inv_line(inv_line), .inv_gnt(inv_gnt)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic issue(input logic [1:0] op, input int core, input int line, input logic tok);
      @(negedge clk);
      req_valid = 1'b1; req_op = op; req_core = CW'(core);
      req_line = LW'(line); req_tok = tok;
      #0.5;
      while (!req_ready) begin @(negedge clk); #0.5; end
      @(posedge clk); #1;
      req_valid = 1'b0;
      r_v = rsp_valid; r_c = rsp_cacheable; r_t = rsp_token; r_a = rsp_ack;
      r_core = rsp_core; r_i = inv_req; r_il = inv_line;
   endtask

   task automatic grant_bus();
      @(negedge clk); inv_gnt = 1'b1;
      @(posedge clk); #1; inv_gnt = 1'b0;
      check("R7 inv_req drops after grant", inv_req, 0);
   endtask

   task automatic t_reset();
      #1;
      check("R1 ready after reset", req_ready, 1);
      check("R1 no rsp after reset", rsp_valid, 0);
      check("R1 no inv after reset", inv_req, 0);
   endtask

   task automatic t_private();
      issue(2'b00, 2, 1, 0);
      check("R2 first read rsp", r_v, 1);
      check("R2 first read cacheable", r_c, 1);
      check("R2 first read token", r_t, 1);
      check("R3 read no ack", r_a, 0);
      check("R10 rsp core", r_core, 2);
      issue(2'b00, 2, 1, 1);
      check("R2 holder reread no token", r_t, 0);
      issue(2'b01, 2, 1, 1);
      check("R3 first private write ack", r_a, 1);
      check("R3 private write cacheable", r_c, 1);
      issue(2'b01, 2, 1, 1);
      check("R3 second write no ack", r_a, 0);
      check("R3 no inv private", r_i, 0);
   endtask

   task automatic t_l1_evict();
      issue(2'b10, 2, 1, 1);
      check("R10 evict no rsp", r_v, 0);
      issue(2'b00, 5, 1, 0);
      check("R4 token regranted", r_t, 1);
      check("R4 cacheable", r_c, 1);
      check("R4 no inv", r_i, 0);
      check("R10 rsp core 5", r_core, 5);
   endtask

   task automatic t_shared_read();
      issue(2'b00, 1, 3, 0);
      check("R2 line3 token", r_t, 1);
      issue(2'b00, 4, 3, 0);
      check("R5 second reader cacheable", r_c, 1);
      check("R5 second reader no token", r_t, 0);
      check("R5 no inv", r_i, 0);
      issue(2'b10, 1, 3, 1);
      issue(2'b00, 7, 3, 0);
      check("R5 sticky shared no token", r_t, 0);
      check("R5 sticky shared cacheable", r_c, 1);
   endtask

   task automatic t_sw_from_shared();
      issue(2'b01, 4, 3, 0);
      check("R6 path a uncacheable", r_c, 0);
      check("R6 path a ack", r_a, 1);
      check("R6 path a inv", r_i, 1);
      check("R6 path a inv line", r_il, 3);
      // same line stalls while pending
      @(negedge clk);
      req_valid = 1'b1; req_op = 2'b00; req_line = 6'd3; req_tok = 1'b0;
      #0.5;
      check("R7 same line stalled", req_ready, 0);
      req_valid = 1'b0;
      issue(2'b00, 8, 9, 0);
      check("R7 other line served", r_v, 1);
      check("R7 other line token", r_t, 1);
      repeat (3) @(posedge clk);
      #1;
      check("R7 inv held", inv_req, 1);
      check("R7 inv line held", inv_line, 3);
      grant_bus();
      issue(2'b00, 1, 3, 1);
      check("R8 read uncacheable", r_c, 0);
      check("R8 read no token", r_t, 0);
      check("R8 no new inv", r_i, 0);
      issue(2'b01, 1, 3, 1);
      check("R8 write ack", r_a, 1);
      check("R8 write uncacheable", r_c, 0);
   endtask

   task automatic t_sw_paths();
      issue(2'b01, 0, 5, 0);
      check("R3 first write absent ack", r_a, 1);
      issue(2'b00, 9, 5, 0);
      check("R6 path b uncacheable", r_c, 0);
      check("R6 path b no ack", r_a, 0);
      check("R6 path b inv", r_i, 1);
      grant_bus();
      issue(2'b00, 0, 6, 0);
      issue(2'b01, 9, 6, 0);
      check("R6 path c uncacheable", r_c, 0);
      check("R6 path c ack", r_a, 1);
      check("R6 path c inv line", r_il, 6);
      grant_bus();
      issue(2'b10, 0, 6, 1);
      issue(2'b00, 0, 6, 0);
      check("R8 evict ignored uncacheable", r_c, 0);
      check("R8 evict ignored no token", r_t, 0);
   endtask

   task automatic t_l2_evict();
      issue(2'b11, 0, 6, 0);
      check("R10 l2 evict no rsp", r_v, 0);
      issue(2'b00, 3, 6, 0);
      check("R9 fresh token", r_t, 1);
      check("R9 fresh cacheable", r_c, 1);
      check("R9 no inv", r_i, 0);
   endtask

   task automatic report();
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      t_reset();
      t_private();
      t_l1_evict();
      t_shared_read();
      t_sw_from_shared();
      t_sw_paths();
      t_l2_evict();
      done = 1;
      report();
   end

   initial begin
      #(5.0 * 100000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         report();
      end
   end

endmodule